// File: doc/BRIEF.md
# Busy Period Timer with Coded Divider Chain

This block measures out a long veto interval after a start strobe. It runs a cascade of clock-enable counters from the system clock. Two stages have fixed division ratios set by parameters, and the ratio of the remaining stages comes from static configuration pins that stand in for board straps. The three strapped stages take their ratios from coded fields rather than from one load value:

- a 3-bit multiplier code with an irregular mapping;
- a second 3-bit code;
- a one-hot selector for the length of a shift-register ring;
- an edge bit that adds a final divide-by-two.

An accepted start raises `busy`. After the configured number of cycles `busy` falls and `done` pulses for one cycle.

The configuration is captured when a start is accepted, so later changes to the straps do not affect a run in progress. A configuration that is not allowed raises `config_error`, and a start made while it is high runs with the built-in fallback setting: multiplier code 110, second code 010, ring length 8 and edge bit 0.

With the default parameters (`BASE_DIV` = 1 with a 10 MHz clock, `PRE_DIV` = 6250), the fallback setting gives 6 × 3 × 8 × 6250 = 900,000 ticks of 100 ns, which is 90 ms.

Top module: `busy_period_timer`

## Requirements
- R1: The multiplier code `m_code` sets a factor as follows: 000→1, 001→10, 010→2, 011→3, 100→4, 101→5, 110→6, 111→12.
- R2: The second code `k_code` sets a factor of code+1 for the patterns 000 through 110, and a factor of 9 for 111.
- R3: Bit i of `n_sel` selects a ring length of i+1, so bit 0 gives 1 and bit 7 gives 8.
- R4: With `s_bit` = 1 the period is twice as long as with `s_bit` = 0, all other settings being equal.
- R5: A start accepted at a clock edge raises `busy` after that edge. `busy` then stays high for exactly BASE_DIV × PRE_DIV × m × k × n × (1 + s) cycles.
- R6: `done` is high for exactly one cycle, the cycle immediately after the last busy cycle, and it is never high while `busy` is high.
- R7: A start that arrives while `busy` is high is ignored, including a start in the last busy cycle. A start in the `done` cycle is accepted.
- R8: `config_error` is high, combinationally from the pins, in either of these cases: `n_sel` does not have exactly one bit set, or `n_sel` selects length 1 while `s_bit` = 0. A start accepted while it is high runs with m code 110, k code 010, n = 8 and s = 0.
- R9: An asynchronous active-low reset clears `busy` and `done` and abandons a run. The next start then behaves normally.
- R10: The configuration is sampled at the accepted start. Changes to `m_code`, `k_code`, `n_sel` or `s_bit` during a run do not change that run's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, sampled at each rising edge |
| m_code | input | 3 | Multiplier stage code |
| k_code | input | 3 | Second stage code |
| n_sel | input | N_MAX | One-hot ring length select |
| s_bit | input | 1 | Edge select; 1 adds a divide-by-two |
| busy | output | 1 | High while a period is running |
| done | output | 1 | One-cycle pulse after the period ends |
| config_error | output | 1 | Current strap setting is illegal |

## Verification
Two events can meet in one cycle: the cycle in which the last stage of the chain expires, and the arrival of a new start strobe. The bench provokes this by raising `start` in the final busy cycle of a short period. It then requires that `busy` falls and `done` pulses exactly as it would without that start. The bench then holds `start` into the `done` cycle and requires that a fresh period of the full length follows with no idle cycle in between.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  localparam int FAC_W = 4;
  typedef logic [FAC_W-1:0] fac_t;

  function automatic fac_t m_factor(input logic [2:0] code);
    fac_t f;
    case (code)
      3'b000:  f = 4'd1;
      3'b001:  f = 4'd10;
      3'b010:  f = 4'd2;
      3'b011:  f = 4'd3;
      3'b100:  f = 4'd4;
      3'b101:  f = 4'd5;
      3'b110:  f = 4'd6;
      default: f = 4'd12;
    endcase
    return f;
  endfunction

  function automatic fac_t k_factor(input logic [2:0] code);
    fac_t f;
    if (code == 3'b111) f = 4'd9;
    else                f = {1'b0, code} + 4'd1;
    return f;
  endfunction

endpackage

// File: rtl/bpt_cfg_decode.sv
module bpt_cfg_decode
  import bpt_pkg::*;
#(
  parameter int         N_MAX      = 8,
  parameter logic [2:0] DEF_M_CODE = 3'b110,
  parameter logic [2:0] DEF_K_CODE = 3'b010,
  parameter int         DEF_N      = 8,
  parameter logic       DEF_S      = 1'b0
) (
  input  logic [2:0]       m_code,
  input  logic [2:0]       k_code,
  input  logic [N_MAX-1:0] n_sel,
  input  logic             s_bit,
  output fac_t             m_fac,
  output fac_t             k_fac,
  output logic             s_eff,
  output logic [N_MAX-1:0] n_mask,
  output logic             cfg_err
);

  localparam logic [N_MAX-1:0] DEF_MASK = N_MAX'(1) << (DEF_N - 1);

  logic single_sel;
  logic short_ring_bad;

  always_comb begin
    single_sel     = (n_sel != '0) && ((n_sel & (n_sel - 1'b1)) == '0);
    short_ring_bad = n_sel[0] && !s_bit;
    cfg_err        = !single_sel || short_ring_bad;
    if (cfg_err) begin
      m_fac  = m_factor(DEF_M_CODE);
      k_fac  = k_factor(DEF_K_CODE);
      s_eff  = DEF_S;
      n_mask = DEF_MASK;
    end else begin
      m_fac  = m_factor(m_code);
      k_fac  = k_factor(k_code);
      s_eff  = s_bit;
      n_mask = n_sel;
    end
  end

endmodule

// File: rtl/bpt_div_stage.sv
module bpt_div_stage #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] div,
  output logic          tc
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tc = en && (cnt_q == (div - 1'b1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = tc ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < div));

endmodule

// File: rtl/bpt_ring_stage.sv
module bpt_ring_stage #(
  parameter int N_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [N_MAX-1:0] last_mask,
  output logic             tc
);

  logic [N_MAX-1:0] token_q;
  logic [N_MAX-1:0] token_d;

  assign tc = en && ((token_q & last_mask) != '0);

  always_comb begin
    token_d = token_q;
    if (clr)     token_d = N_MAX'(1);
    else if (en) token_d = tc ? N_MAX'(1) : (token_q << 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) token_q <= N_MAX'(1);
    else        token_q <= token_d;
  end

  // R3
  token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(token_q));

endmodule

// File: rtl/busy_period_timer.sv
module busy_period_timer
  import bpt_pkg::*;
#(
  parameter int         BASE_DIV   = 1,
  parameter int         PRE_DIV    = 6250,
  parameter int         N_MAX      = 8,
  parameter logic [2:0] DEF_M_CODE = 3'b110,
  parameter logic [2:0] DEF_K_CODE = 3'b010,
  parameter int         DEF_N      = 8,
  parameter logic       DEF_S      = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       m_code,
  input  logic [2:0]       k_code,
  input  logic [N_MAX-1:0] n_sel,
  input  logic             s_bit,
  output logic             busy,
  output logic             done,
  output logic             config_error
);

  localparam int NFIX    = 2;
  localparam int NRT     = 3;
  localparam int FIX_MAX = (BASE_DIV > PRE_DIV) ? BASE_DIV : PRE_DIV;
  localparam int FIX_W   = $clog2(FIX_MAX + 1);
  localparam int FIX_DIV [NFIX] = '{BASE_DIV, PRE_DIV};
  localparam logic [N_MAX-1:0] DEF_MASK = N_MAX'(1) << (DEF_N - 1);

  // decoded configuration
  fac_t             dec_m, dec_k;
  logic             dec_s;
  logic [N_MAX-1:0] dec_mask;
  logic             dec_err;

  bpt_cfg_decode #(
    .N_MAX(N_MAX), .DEF_M_CODE(DEF_M_CODE), .DEF_K_CODE(DEF_K_CODE),
    .DEF_N(DEF_N), .DEF_S(DEF_S)
  ) u_decode (
    .m_code (m_code),
    .k_code (k_code),
    .n_sel  (n_sel),
    .s_bit  (s_bit),
    .m_fac  (dec_m),
    .k_fac  (dec_k),
    .s_eff  (dec_s),
    .n_mask (dec_mask),
    .cfg_err(dec_err)
  );

  assign config_error = dec_err;

  // captured configuration and control state
  fac_t             cap_m_q, cap_k_q;
  logic             cap_s_q;
  logic [N_MAX-1:0] cap_mask_q;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             accept;
  logic             expire;

  assign accept = start && !busy_q;

  always_comb begin
    busy_d = busy_q;
    if (accept)      busy_d = 1'b1;
    else if (expire) busy_d = 1'b0;
    done_d = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_m_q    <= 4'd1;
      cap_k_q    <= 4'd1;
      cap_s_q    <= 1'b0;
      cap_mask_q <= N_MAX'(1);
    end else if (accept) begin
      cap_m_q    <= dec_m;
      cap_k_q    <= dec_k;
      cap_s_q    <= dec_s;
      cap_mask_q <= dec_mask;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // enable chain: [0] busy, fixed stages, strapped stages, ring
  logic en_chain [NFIX+NRT+2];
  assign en_chain[0] = busy_q;

  for (genvar g = 0; g < NFIX; g++) begin : g_fix
    if (FIX_DIV[g] > 1) begin : g_cnt
      bpt_div_stage #(.CW(FIX_W)) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .en   (en_chain[g]),
        .div  (FIX_W'(FIX_DIV[g])),
        .tc   (en_chain[g+1])
      );
    end else begin : g_pass
      assign en_chain[g+1] = en_chain[g];
    end
  end

  fac_t rt_div [NRT];
  assign rt_div[0] = cap_m_q;
  assign rt_div[1] = cap_k_q;
  assign rt_div[2] = cap_s_q ? 4'd2 : 4'd1;

  for (genvar r = 0; r < NRT; r++) begin : g_rt
    bpt_div_stage #(.CW(FAC_W)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (accept),
      .en   (en_chain[NFIX+r]),
      .div  (rt_div[r]),
      .tc   (en_chain[NFIX+r+1])
    );
  end

  bpt_ring_stage #(.N_MAX(N_MAX)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .en       (en_chain[NFIX+NRT]),
    .last_mask(cap_mask_q),
    .tc       (en_chain[NFIX+NRT+1])
  );

  assign expire = en_chain[NFIX+NRT+1];

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R6
  fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !expire) |=> busy_q);

  // R10
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(cap_m_q) && $stable(cap_k_q) && $stable(cap_mask_q)
                && $stable(cap_s_q)));

  // R8
  fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_err) |=> (cap_mask_q == DEF_MASK) && (cap_s_q == DEF_S)
                            && (cap_m_q == m_factor(DEF_M_CODE)));

endmodule

// File: tb/busy_period_timer_bench.sv
module busy_period_timer_bench;

  typedef struct packed {
    logic [2:0]  m;
    logic [2:0]  k;
    logic [7:0]  n;
    logic        s;
    int unsigned cyc;
    logic        err;
  } vec_t;

  // PRE_DIV = 2, BASE_DIV = 1: cycles = 2*m*k*n*(1+s)
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 3'b000, 8'h02, 1'b0, 4,    1'b0},
    '{3'b010, 3'b001, 8'h01, 1'b1, 16,   1'b0},
    '{3'b011, 3'b010, 8'h04, 1'b0, 54,   1'b0},
    '{3'b100, 3'b011, 8'h08, 1'b0, 128,  1'b0},
    '{3'b101, 3'b100, 8'h10, 1'b1, 500,  1'b0},
    '{3'b110, 3'b101, 8'h20, 1'b0, 432,  1'b0},
    '{3'b001, 3'b110, 8'h40, 1'b0, 980,  1'b0},
    '{3'b111, 3'b111, 8'h80, 1'b1, 3456, 1'b0},
    '{3'b000, 3'b000, 8'h01, 1'b0, 288,  1'b1},
    '{3'b000, 3'b000, 8'h00, 1'b1, 288,  1'b1},
    '{3'b011, 3'b011, 8'h11, 1'b0, 288,  1'b1},
    '{3'b000, 3'b000, 8'h01, 1'b1, 4,    1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] m_code = 3'b000;
  logic [2:0] k_code = 3'b000;
  logic [7:0] n_sel = 8'h80;
  logic       s_bit = 1'b0;
  logic       busy, done, config_error;

  int n_run  = 0;
  int n_fail = 0;

  busy_period_timer #(.BASE_DIV(1), .PRE_DIV(2)) u_busy_period_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .m_code(m_code),
    .k_code(k_code), .n_sel(n_sel), .s_bit(s_bit), .busy(busy),
    .done(done), .config_error(config_error)
  );

  initial forever #4 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic [2:0] k,
                         input logic [7:0] n, input logic s);
    m_code = m; k_code = k; n_sel = n; s_bit = s;
  endtask

  // called at a negedge with start driven; returns busy cycles seen
  task automatic pulse_start_and_count(output int c);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (busy && c < 10000) begin
      c++;
      @(negedge clk);
    end
  endtask

  int cnt;
  int cnt2;

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 busy in reset", busy, 0);
    chk(done == 1'b0, "R9 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 idle after reset", busy, 0);

    // table: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      set_cfg(VECS[i].m, VECS[i].k, VECS[i].n, VECS[i].s);
      @(negedge clk);
      chk(config_error == VECS[i].err, "R8 config_error", config_error, VECS[i].err);
      pulse_start_and_count(cnt);
      chk(cnt == int'(VECS[i].cyc), "R5 period (R1 R2 R3 R4 R8)", cnt, VECS[i].cyc);
      chk(done == 1'b1, "R6 done after busy", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R6 done single cycle", done, 0);
    end

    // R4: same setting, edge bit toggled
    set_cfg(3'b010, 3'b000, 8'h04, 1'b0);
    @(negedge clk);
    pulse_start_and_count(cnt);
    @(negedge clk);
    s_bit = 1'b1;
    @(negedge clk);
    pulse_start_and_count(cnt2);
    chk(cnt == 12, "R4 single length", cnt, 12);
    chk(cnt2 == 2 * cnt, "R4 doubled length", cnt2, 2 * cnt);
    @(negedge clk);

    // R7: start in middle of run ignored
    set_cfg(3'b011, 3'b010, 8'h04, 1'b0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    repeat (9) begin @(negedge clk); cnt++; end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt++;
    while (busy && cnt < 10000) begin @(negedge clk); if (busy) cnt++; end
    chk(cnt == 54, "R7 mid-run start ignored", cnt, 54);
    @(negedge clk);

    // R10: straps changed during run
    set_cfg(3'b100, 3'b011, 8'h08, 1'b0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    set_cfg(3'b000, 3'b000, 8'h01, 1'b1);
    cnt = 0;
    while (busy && cnt < 10000) begin cnt++; @(negedge clk); end
    chk(cnt == 128, "R10 capture at start", cnt, 128);
    @(negedge clk);

    // R7: start in last busy cycle ignored, start in done cycle accepted
    set_cfg(3'b000, 3'b000, 8'h02, 1'b0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R7 last busy cycle", busy, 1);
    start = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R7 start at expiry ignored", busy, 0);
    chk(done == 1'b1, "R7 done at expiry", done, 1);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 start in done cycle accepted", busy, 1);
    cnt = 0;
    while (busy && cnt < 10000) begin cnt++; @(negedge clk); end
    chk(cnt == 4, "R7 restarted period length", cnt, 4);
    @(negedge clk);

    // R9: reset during a run
    set_cfg(3'b100, 3'b011, 8'h08, 1'b0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy == 1'b0, "R9 async reset clears busy", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R9 no done after reset", done, 0);
    pulse_start_and_count(cnt);
    chk(cnt == 128, "R9 run after reset", cnt, 128);
    chk(done == 1'b1, "R9 done after reset run", done, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule